// File: doc/BRIEF.md
# Picture Processor CPU Register Port with Buffered Data Access

This block is the processor-facing side of a picture processor. It decodes every CPU access in the window 0x2000-0x3FFF into one of eight registers, keeps the 14-bit video address, and serves the data register. Reads of ordinary video memory come through a one-byte delay buffer: each read returns the byte fetched by the read before it. Reads in the colour table region at 0x3F00 and above are answered at once from a small colour table held inside the block. The block also holds a bus latch, and every register that has no read function of its own answers with that latch.

Video memory outside the colour table sits behind a single-cycle request port. In the cycle of the request the block drives the address and a read or write strobe, and the memory answers in that same cycle. A data-register read at or above 0x3F00 also uses this port: it refills the buffer from the address 0x1000 lower, which is the nametable area under the colour table. Rendering, object handling, fine scroll and any status flags are outside this block. In this block only the data register (index 7) has a read function.

Top module: `ppu_regport`

## Requirements
- R1: An access is decoded only when cpu_addr[15:13] is 3'b001. cpu_addr[2:0] then selects the register (0 control, 6 address pointer, 7 data, the rest latch-only), so every 8-byte copy behaves alike. An access outside the window drives no video strobe and changes nothing, and a read outside the window returns 0.
- R2: A data read with the video address below 0x3F00 returns the buffer. In the same cycle it drives vm_rd with vm_addr equal to the video address, and vm_rdata becomes the new buffer.
- R3: A data read with the video address at 0x3F00 or above returns the colour-table byte in the same cycle. It drives vm_rd with vm_addr equal to the video address minus 0x1000, and loads the buffer from vm_rdata.
- R4: Every data read or write advances the video address by 1, or by 32 when bit 2 of the last control write was 1. The address is 14 bits wide, so 0x3FFF advances to 0x0000.
- R5: The first write to register 6 supplies address bits 13:8 from data bits 5:0 (data bits 7:6 are ignored). The second write supplies bits 7:0, and only then does the video address change. The write order starts again with the first write after reset.
- R6: A data write below 0x3F00 drives vm_wr with vm_addr equal to the video address and vm_wdata equal to cpu_wdata. A data write at or above 0x3F00 stores into the colour table and drives no vm_wr.
- R7: The colour table has 32 entries, indexed by address bits 4:0, and repeats across 0x3F00-0x3FFF. Indices 0x10, 0x14, 0x18 and 0x1C are the same entries as 0x00, 0x04, 0x08 and 0x0C. All other indices are distinct.
- R8: A read of registers 0-6 returns the last byte that crossed the register bus: the data of the last in-window write, or the value returned by the last in-window read.
- R9: Writes to any register, and reads of registers 0-6, leave the buffer unchanged. The buffer also holds through any number of idle cycles and through changes of the character memory contents after it was filled.
- R10: After reset the video address, buffer, bus latch, step select, write order and colour table are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access (wins over cpu_rd) |
| cpu_rdata | output | 8 | Read data, valid in the cycle of cpu_rd |
| vm_addr | output | 14 | Video memory address |
| vm_rd | output | 1 | Video memory read request |
| vm_wr | output | 1 | Video memory write request |
| vm_wdata | output | 8 | Video memory write data |
| vm_rdata | input | 8 | Video memory read data, same cycle as vm_rd |

## Verification
A colour-table read does two things in one cycle. It returns the table byte directly, and it refills the buffer from the nametable byte 0x1000 lower. In the same edge the bus latch takes the returned value while the buffer takes the fetched value. The bench provokes this by reading at 0x3F05, at 0x3EFF then 0x3F00, and across the 0x3FFF wrap. It then reads the following ordinary address and reads a latch-only register. Its reference model decides whether each value came from the buffer, from the colour table or from the latch, and it also checks the address presented on the memory port in every one of those cycles.

// File: rtl/ppu_regport_pkg.sv
package ppu_regport_pkg;

  localparam int VA_W   = 14;
  localparam int PAL_AW = 5;

  typedef logic [VA_W-1:0] vaddr_t;

  localparam vaddr_t PAL_BASE = 14'h3F00;
  localparam vaddr_t FILL_OFS = 14'h1000;

  typedef enum logic [2:0] {
    REG_CONFIG   = 3'd0,
    REG_DISPLAY  = 3'd1,
    REG_STATUS   = 3'd2,
    REG_OBJ_PTR  = 3'd3,
    REG_OBJ_DATA = 3'd4,
    REG_SCROLL   = 3'd5,
    REG_POINTER  = 3'd6,
    REG_DATA     = 3'd7
  } reg_e;

  // colour table region test
  function automatic logic is_pal(vaddr_t v);
    return v >= PAL_BASE;
  endfunction

  // address fetched into the buffer by a data read
  function automatic vaddr_t fill_addr(vaddr_t v);
    return is_pal(v) ? vaddr_t'(v - FILL_OFS) : v;
  endfunction

  // colour table index with the backdrop aliases folded
  function automatic logic [PAL_AW-1:0] pal_idx(vaddr_t v);
    logic [PAL_AW-1:0] i;
    i = v[PAL_AW-1:0];
    if (i[1:0] == 2'b00) i[PAL_AW-1] = 1'b0;
    return i;
  endfunction

  // post-access address advance, wraps in VA_W bits
  function automatic vaddr_t step(vaddr_t v, logic wide, int unsigned big);
    return vaddr_t'(v + (wide ? vaddr_t'(big) : vaddr_t'(1)));
  endfunction

endpackage

// File: rtl/ppu_addr_unit.sv
module ppu_addr_unit
  import ppu_regport_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int WIDE_STEP = 32,
  parameter int STEP_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              ptr_we,
  input  logic              advance,
  input  logic [DATA_W-1:0] wdata,
  output vaddr_t            vaddr,
  output logic              wide
);

  localparam int HI_W = VA_W - DATA_W;

  logic [HI_W-1:0] hi_q;
  logic            second_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaddr    <= '0;
      wide     <= 1'b0;
      hi_q     <= '0;
      second_q <= 1'b0;
    end else begin
      if (ctrl_we) wide <= wdata[STEP_BIT];
      if (ptr_we) begin
        if (!second_q) begin
          hi_q     <= wdata[HI_W-1:0];
          second_q <= 1'b1;
        end else begin
          vaddr    <= {hi_q, wdata};
          second_q <= 1'b0;
        end
      end else if (advance) begin
        vaddr <= step(vaddr, wide, WIDE_STEP);
      end
    end
  end

endmodule

// File: rtl/ppu_palette_ram.sv
module ppu_palette_ram #(
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [$clog2(ENTRIES)-1:0] idx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata
);

  logic [DATA_W-1:0] tbl [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (we) begin
      tbl[idx] <= wdata;
    end
  end

  assign rdata = tbl[idx];

endmodule

// File: rtl/ppu_read_path.sv
module ppu_read_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_acc,
  input  logic              wr_acc,
  input  logic              dp_rd,
  input  logic              pal_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] vm_rdata,
  input  logic [DATA_W-1:0] pal_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] buf_q,
  output logic [DATA_W-1:0] obus_q
);

  always_comb begin
    if (!rd_acc)      rdata = '0;
    else if (!dp_rd)  rdata = obus_q;
    else if (pal_hit) rdata = pal_rdata;
    else              rdata = buf_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      obus_q <= '0;
    end else begin
      if (dp_rd) buf_q <= vm_rdata;
      if (wr_acc)      obus_q <= wdata;
      else if (rd_acc) obus_q <= rdata;
    end
  end

endmodule

// File: rtl/ppu_regport.sv
module ppu_regport
  import ppu_regport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int WIDE_STEP   = 32,
  parameter int STEP_BIT    = 2,
  parameter int PAL_ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [VA_W-1:0]   vm_addr,
  output logic              vm_rd,
  output logic              vm_wr,
  output logic [DATA_W-1:0] vm_wdata,
  input  logic [DATA_W-1:0] vm_rdata
);

  localparam int PIX_W = $clog2(PAL_ENTRIES);

  // named internal events
  logic              in_range;
  reg_e              reg_sel;
  logic              rd_acc, wr_acc;
  logic              dp_rd, dp_wr;
  logic              pal_hit;
  logic              wide_q;
  vaddr_t            vaddr_q;
  logic [DATA_W-1:0] buf_q, obus_q, pal_rdata;
  logic [PIX_W-1:0]  pal_index;

  assign in_range  = (cpu_addr[15:13] == 3'b001);
  assign reg_sel   = reg_e'(cpu_addr[2:0]);
  assign wr_acc    = in_range & cpu_wr;
  assign rd_acc    = in_range & cpu_rd & ~cpu_wr;
  assign dp_rd     = rd_acc & (reg_sel == REG_DATA);
  assign dp_wr     = wr_acc & (reg_sel == REG_DATA);
  assign pal_hit   = is_pal(vaddr_q);
  assign pal_index = PIX_W'(pal_idx(vaddr_q));

  ppu_addr_unit #(
    .DATA_W(DATA_W), .WIDE_STEP(WIDE_STEP), .STEP_BIT(STEP_BIT)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_we (wr_acc & (reg_sel == REG_CONFIG)),
    .ptr_we  (wr_acc & (reg_sel == REG_POINTER)),
    .advance (dp_rd | dp_wr),
    .wdata   (cpu_wdata),
    .vaddr   (vaddr_q),
    .wide    (wide_q)
  );

  ppu_palette_ram #(
    .DATA_W(DATA_W), .ENTRIES(PAL_ENTRIES)
  ) u_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (dp_wr & pal_hit),
    .idx   (pal_index),
    .wdata (cpu_wdata),
    .rdata (pal_rdata)
  );

  ppu_read_path #(
    .DATA_W(DATA_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_acc    (rd_acc),
    .wr_acc    (wr_acc),
    .dp_rd     (dp_rd),
    .pal_hit   (pal_hit),
    .wdata     (cpu_wdata),
    .vm_rdata  (vm_rdata),
    .pal_rdata (pal_rdata),
    .rdata     (cpu_rdata),
    .buf_q     (buf_q),
    .obus_q    (obus_q)
  );

  assign vm_rd    = dp_rd;
  assign vm_wr    = dp_wr & ~pal_hit;
  assign vm_addr  = dp_rd ? fill_addr(vaddr_q) : vaddr_q;
  assign vm_wdata = cpu_wdata;

endmodule

// File: rtl/ppu_regport_chk.sv
module ppu_regport_chk
  import ppu_regport_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int WIDE_STEP = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_range,
  input logic              rd_acc,
  input logic              dp_rd,
  input logic              dp_wr,
  input logic              pal_hit,
  input logic              wide_q,
  input vaddr_t            vaddr_q,
  input logic [DATA_W-1:0] buf_q,
  input logic [DATA_W-1:0] obus_q,
  input logic [DATA_W-1:0] cpu_rdata,
  input vaddr_t            vm_addr,
  input logic              vm_rd,
  input logic              vm_wr,
  input logic [DATA_W-1:0] vm_rdata
);

  assert_outside_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> (!vm_rd && !vm_wr && cpu_rdata == '0));

  assert_buffer_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rd |=> buf_q == $past(vm_rdata));

  assert_pal_fill_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd && pal_hit) |-> (vm_rd && vm_addr == vaddr_t'(vaddr_q - 14'h1000)));

  assert_addr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd || dp_wr) |=> vaddr_q == vaddr_t'($past(vaddr_q) +
      ($past(wide_q) ? vaddr_t'(WIDE_STEP) : vaddr_t'(1))));

  assert_pal_no_vmwr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && pal_hit) |-> !vm_wr);

  assert_latch_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> obus_q == $past(cpu_rdata));

  assert_buffer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_rd |=> $stable(buf_q));

endmodule

bind ppu_regport ppu_regport_chk #(.DATA_W(DATA_W), .WIDE_STEP(WIDE_STEP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_range  (in_range),
  .rd_acc    (rd_acc),
  .dp_rd     (dp_rd),
  .dp_wr     (dp_wr),
  .pal_hit   (pal_hit),
  .wide_q    (wide_q),
  .vaddr_q   (vaddr_q),
  .buf_q     (buf_q),
  .obus_q    (obus_q),
  .cpu_rdata (cpu_rdata),
  .vm_addr   (vm_addr),
  .vm_rd     (vm_rd),
  .vm_wr     (vm_wr),
  .vm_rdata  (vm_rdata)
);

// File: tb/tb_ppu_regport.sv
`timescale 1ns/1ps
module tb_ppu_regport;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_rdata;
  logic [13:0] vm_addr;
  logic        vm_rd, vm_wr;
  logic [7:0]  vm_wdata, vm_rdata;

  always #10 clk = ~clk;

  ppu_regport dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .vm_addr(vm_addr), .vm_rd(vm_rd), .vm_wr(vm_wr), .vm_wdata(vm_wdata),
    .vm_rdata(vm_rdata)
  );

  // external video memory, character area remapped by a bank mask
  logic [7:0] mem [16384];
  logic [7:0] bank;
  assign vm_rdata = mem[vm_addr] ^ ((vm_addr < 14'h2000) ? bank : 8'h00);

  function automatic logic [7:0] content(int a);
    return mem[a] ^ ((a < 'h2000) ? bank : 8'h00);
  endfunction

  // behavioural reference state
  int    m_vaddr, m_buf, m_obus, m_hi;
  bit    m_wide, m_second;
  int    m_pal [32];
  int    n_chk, n_fail;
  string phase;

  function automatic int midx(int v);
    int k;
    k = v % 32;
    if (k % 4 == 0) k = k % 16;
    return k;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (phase %s) actual=%0h expected=%0h at %0t", req, phase, act, exp, $time);
    end
  endtask

  task automatic model_advance();
    m_vaddr = (m_vaddr + (m_wide ? 32 : 1)) % 16384;
  endtask

  task automatic access(input bit is_wr, input logic [15:0] a, input logic [7:0] d);
    int  r, exp, fa;
    bit  pal, w_hit;
    logic [13:0] w_a;
    logic [7:0]  w_d;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rd = !is_wr; cpu_wr = is_wr;
    #5;
    r   = int'(a[2:0]);
    pal = (m_vaddr >= 'h3F00);
    if (a[15:13] != 3'b001) begin
      chk(!vm_rd && !vm_wr, "R1", {vm_rd, vm_wr}, 0);
      if (!is_wr) chk(cpu_rdata == 8'h00, "R1", cpu_rdata, 0);
    end else if (!is_wr) begin
      if (r == 7) begin
        exp = pal ? m_pal[midx(m_vaddr)] : m_buf;
        fa  = pal ? m_vaddr - 'h1000 : m_vaddr;
        chk(cpu_rdata == exp[7:0], pal ? "R3" : "R2", cpu_rdata, exp);
        chk(vm_rd && !vm_wr && vm_addr == fa[13:0], pal ? "R3" : "R2", vm_addr, fa);
        m_buf  = content(fa);
        m_obus = exp;
        model_advance();
      end else begin
        chk(cpu_rdata == m_obus[7:0], "R8", cpu_rdata, m_obus);
        chk(!vm_rd && !vm_wr, "R9", {vm_rd, vm_wr}, 0);
      end
    end else begin
      m_obus = d;
      chk(!vm_rd, "R6", vm_rd, 0);
      if (r == 0) m_wide = d[2];
      if (r == 6) begin
        if (!m_second) begin m_hi = d & 'h3F; m_second = 1; end
        else begin m_vaddr = m_hi * 256 + d; m_second = 0; end
      end
      if (r == 7) begin
        if (pal) begin
          m_pal[midx(m_vaddr)] = d;
          chk(!vm_wr, "R6", vm_wr, 0);
        end else begin
          chk(vm_wr && vm_addr == m_vaddr[13:0] && vm_wdata == d, "R6", vm_addr, m_vaddr);
        end
        model_advance();
      end else begin
        chk(!vm_wr, "R6", vm_wr, 0);
      end
    end
    w_hit = vm_wr; w_a = vm_addr; w_d = vm_wdata;
    @(posedge clk);
    if (w_hit) mem[w_a] = w_d;
    #1;
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #5;
      chk(!vm_rd && !vm_wr, "R9", {vm_rd, vm_wr}, 0);
      @(posedge clk);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d); access(1'b1, a, d); endtask
  task automatic rd(input logic [15:0] a); access(1'b0, a, 8'h00); endtask
  task automatic set_ptr(input int v);
    wr(16'h2006, 8'(v / 256)); wr(16'h2006, 8'(v % 256));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; bank = 8'h00; phase = "R10";
    for (int i = 0; i < 16384; i++) mem[i] = 8'((i * 37 + i / 256) % 256);
    m_vaddr = 0; m_buf = 0; m_obus = 0; m_hi = 0; m_wide = 0; m_second = 0;
    for (int i = 0; i < 32; i++) m_pal[i] = 0;
    rst_n = 1'b0; cpu_addr = 16'h0000; cpu_wdata = 8'h00; cpu_rd = 1'b0; cpu_wr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10: reset state seen at the ports
    rd(16'h2002);
    rd(16'h2007);
    rd(16'h3F10);

    phase = "R5";  // upper address bits ignored, two-step load
    set_ptr('hE400);
    rd(16'h2007); rd(16'h2007); rd(16'h2007);

    phase = "R1";  // mirrored copies of the data register
    rd(16'h3FFF); rd(16'h2A0F); rd(16'h35B7);
    wr(16'h4007, 8'h99); rd(16'h1FFF); rd(16'h8007);
    rd(16'h2001);

    phase = "R4";  // step of 32, then wrap of the 14-bit address
    wr(16'h2000, 8'h04);
    set_ptr('h2010);
    for (int i = 0; i < 4; i++) rd(16'h2007);
    wr(16'h2000, 8'h00);
    set_ptr('h3FFE);
    for (int i = 0; i < 4; i++) rd(16'h2007);

    phase = "R6";  // data writes to memory and readback
    set_ptr('h2100);
    for (int i = 0; i < 5; i++) wr(16'h2007, 8'(8'hA0 + i));
    wr(16'h2000, 8'h04);
    for (int i = 0; i < 3; i++) wr(16'h2007, 8'(8'h50 + i));
    wr(16'h2000, 8'h00);
    set_ptr('h2100);
    for (int i = 0; i < 6; i++) rd(16'h2007);

    phase = "R7";  // colour table fill and aliases
    set_ptr('h3F00);
    for (int i = 0; i < 32; i++) wr(16'h2007, 8'(8'h10 + i * 3));
    set_ptr('h3F00);
    for (int i = 0; i < 32; i++) rd(16'h2007);
    set_ptr('h3F64); rd(16'h2007); rd(16'h2007);
    set_ptr('h3FF8); rd(16'h2007);

    phase = "R3";  // direct colour read plus refill from below
    set_ptr('h3F05); rd(16'h2007);
    set_ptr('h0000); rd(16'h2007);
    set_ptr('h3EFF); rd(16'h2007); rd(16'h2007); rd(16'h2007);
    set_ptr('h3FFF); rd(16'h2007); rd(16'h2007); rd(16'h2007);

    phase = "R8";  // latch carries the last transfer
    wr(16'h2003, 8'h5A); rd(16'h2000); rd(16'h2004);
    set_ptr('h2200); rd(16'h2007); rd(16'h2005);
    set_ptr('h3F01); rd(16'h2007); rd(16'h2006);

    phase = "R9";  // buffer untouched by other traffic, idle and bank change
    set_ptr('h1B40); rd(16'h2007);
    for (int r = 0; r < 6; r++) wr(16'(16'h2000 + r), 8'(8'hC0 + r));
    wr(16'h2006, 8'h1B); wr(16'h2006, 8'h44);
    for (int r = 0; r < 7; r++) rd(16'(16'h2008 + r));
    wr(16'h2007, 8'h77);
    idle(300);
    bank = 8'hFF;
    idle(5);
    rd(16'h2007);
    rd(16'h2007);
    bank = 8'h00;
    rd(16'h2007);

    finish_run();
  end

endmodule